// File: doc/BRIEF.md
# Serial DAC Write Controller

This block turns a one-cycle parallel write request into the pin sequence of a three-wire, double-buffered serial DAC input port. On a write it sends a code word most significant bit first on a data line, with a serial clock it generates itself. It then pulses an active-low load strobe, which moves the device's shift register into its converter register, and raises `done` for one cycle.

A separate request drives an active-low clear pulse that zeroes the converter register. The controller also issues one clear pulse by itself after reset. Every interval is counted in system clock cycles and set by a parameter, so the integrator rounds each nanosecond minimum up to whole clock periods. Examples are serial clock high and low time, load setup after the last clock, load width, load hold and clear width.

While `busy` is high, new requests of either kind are dropped and nothing is queued.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: While reset is held, `dac_sclk` is 0, `dac_ld_n` is 1, `dac_clr_n` is 1 and `busy` is 1. After reset releases, the block drives exactly one low pulse on `dac_clr_n` of CLR_CYC cycles. It then drops `busy` and accepts requests.
- R2: A write sends `wr_code` on `dac_sdo` most significant bit first. It makes exactly DATA_W rising edges of `dac_sclk`, and the bit present at the k-th rising edge is bit DATA_W-k of the code.
- R3: During a write, each high phase of `dac_sclk` lasts exactly SCK_HI_CYC cycles. Each low phase between two rising edges lasts exactly SCK_LO_CYC cycles. `dac_sclk` idles low.
- R4: `dac_sdo` never changes while `dac_sclk` stays high.
- R5: `dac_ld_n` stays high while `dac_sclk` is high. It falls exactly LD_SU_CYC cycles after the last falling edge of `dac_sclk` and stays low exactly LD_W_CYC cycles, once per write.
- R6: `busy` is high from the cycle after a request is accepted. After a write it falls exactly LD_HOLD_CYC cycles after `dac_ld_n` rises, and `done` pulses for one cycle in that same cycle.
- R7: A write or clear request that arrives while `busy` is high is ignored. The running write completes with its own code and sends no extra clock, load or clear pulse.
- R8: A clear request while idle drives `dac_clr_n` low for exactly CLR_CYC cycles, with no clock or load activity and no `done`. When a write and a clear arrive in the same cycle, the clear wins and the write is dropped.
- R9: `dac_ld_n` and `dac_clr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | One-cycle write request, sampled when idle |
| wr_code | input | DATA_W | Code to send, captured with `wr_req` |
| clr_req | input | 1 | One-cycle clear request, sampled when idle |
| busy | output | 1 | A sequence is running; requests are dropped |
| done | output | 1 | One-cycle pulse at the end of a write |
| dac_sclk | output | 1 | Serial clock to the DAC, idles low |
| dac_sdo | output | 1 | Serial data to the DAC, changes on the falling clock edge |
| dac_ld_n | output | 1 | Active-low load strobe |
| dac_clr_n | output | 1 | Active-low clear |

## Verification
The hardest situation to reach is a request landing in the middle of a running write, where a faulty design would restart the shift or start a clear pulse. The bench raises a second write with a different code, together with a clear request, twenty cycles into a transfer. It then confirms at the pins that the first code alone came out, with a single load pulse and no clear pulse. The clear-beats-write ordering is reached by raising both requests in the same cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_CLR,
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_LDSU,
        ST_LDLOW,
        ST_LDHOLD
    } sdac_state_e;
endpackage

// File: rtl/sdac_gap_timer.sv
module sdac_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // The count only moves down between loads, so a stretch never lasts longer than its load value.
    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q < $past(cnt_q))); // R3
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
    parameter int DATA_W    = 12,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              sout
);
    logic [DATA_W-1:0] sh_d, sh_q;

    generate
        if (MSB_FIRST) begin : g_msb
            always_comb begin
                sh_d = sh_q;
                if (load)       sh_d = din;
                else if (shift) sh_d = {sh_q[DATA_W-2:0], 1'b0};
            end
            assign sout = sh_q[DATA_W-1];
        end else begin : g_lsb
            always_comb begin
                sh_d = sh_q;
                if (load)       sh_d = din;
                else if (shift) sh_d = {1'b0, sh_q[DATA_W-1:1]};
            end
            assign sout = sh_q[0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    AST_SH_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R2
endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
    import sdac_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SCK_HI_CYC  = 5,
    parameter int SCK_LO_CYC  = 5,
    parameter int LD_SU_CYC   = 3,
    parameter int LD_W_CYC    = 3,
    parameter int LD_HOLD_CYC = 4,
    parameter int CLR_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_code,
    input  logic              clr_req,
    output logic              busy,
    output logic              done,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              dac_ld_n,
    output logic              dac_clr_n
);
    localparam int MAX_A = (SCK_HI_CYC > SCK_LO_CYC) ? SCK_HI_CYC : SCK_LO_CYC;
    localparam int MAX_B = (LD_SU_CYC > LD_W_CYC) ? LD_SU_CYC : LD_W_CYC;
    localparam int MAX_C = (LD_HOLD_CYC > CLR_CYC) ? LD_HOLD_CYC : CLR_CYC;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W = (MAX_ALL > 1) ? $clog2(MAX_ALL) : 1;
    localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        sdac_state_e      state;
        logic [BIT_W-1:0] bits;
        logic             sclk;
        logic             ld_n;
        logic             clr_n;
        logic             busy;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             sh_load;
    logic             sh_shift;

    sdac_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdac_shreg #(.DATA_W(DATA_W), .MSB_FIRST(1'b1)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (wr_code),
        .sout  (dac_sdo)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        case (ctl_q.state)
            ST_BOOT: begin
                ctl_d.clr_n = 1'b0;
                ctl_d.state = ST_CLR;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(CLR_CYC - 1);
            end
            ST_CLR: begin
                if (tmr_exp) begin
                    ctl_d.clr_n = 1'b1;
                    ctl_d.busy  = 1'b0;
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (clr_req) begin
                    ctl_d.clr_n = 1'b0;
                    ctl_d.busy  = 1'b1;
                    ctl_d.state = ST_CLR;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(CLR_CYC - 1);
                end else if (wr_req) begin
                    sh_load     = 1'b1;
                    ctl_d.busy  = 1'b1;
                    ctl_d.bits  = BIT_W'(DATA_W - 1);
                    ctl_d.state = ST_LO;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(SCK_LO_CYC - 1);
                end
            end
            ST_LO: begin
                if (tmr_exp) begin
                    ctl_d.sclk  = 1'b1;
                    ctl_d.state = ST_HI;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(SCK_HI_CYC - 1);
                end
            end
            ST_HI: begin
                if (tmr_exp) begin
                    ctl_d.sclk = 1'b0;
                    tmr_load   = 1'b1;
                    if (ctl_q.bits != '0) begin
                        sh_shift    = 1'b1;
                        ctl_d.bits  = ctl_q.bits - 1'b1;
                        ctl_d.state = ST_LO;
                        tmr_val     = CNT_W'(SCK_LO_CYC - 1);
                    end else begin
                        ctl_d.state = ST_LDSU;
                        tmr_val     = CNT_W'(LD_SU_CYC - 1);
                    end
                end
            end
            ST_LDSU: begin
                if (tmr_exp) begin
                    ctl_d.ld_n  = 1'b0;
                    ctl_d.state = ST_LDLOW;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(LD_W_CYC - 1);
                end
            end
            ST_LDLOW: begin
                if (tmr_exp) begin
                    ctl_d.ld_n  = 1'b1;
                    ctl_d.state = ST_LDHOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(LD_HOLD_CYC - 1);
                end
            end
            ST_LDHOLD: begin
                if (tmr_exp) begin
                    ctl_d.busy  = 1'b0;
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_BOOT;
            ctl_q.bits  <= '0;
            ctl_q.sclk  <= 1'b0;
            ctl_q.ld_n  <= 1'b1;
            ctl_q.clr_n <= 1'b1;
            ctl_q.busy  <= 1'b1;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = ctl_q.busy;
    assign done      = ctl_q.done;
    assign dac_sclk  = ctl_q.sclk;
    assign dac_ld_n  = ctl_q.ld_n;
    assign dac_clr_n = ctl_q.clr_n;

    AST_LD_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dac_ld_n && !dac_clr_n)); // R9
    AST_NO_LD_IN_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> dac_ld_n); // R5
    AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |=> (!dac_sclk || $stable(dac_sdo))); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_LD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> busy); // R6
    AST_SCLK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> busy); // R7
endmodule

// File: tb/sdac_wr_ctrl_bench.sv
module sdac_wr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int HI   = 5;
    localparam int LO   = 5;
    localparam int LDSU = 3;
    localparam int LDW  = 3;
    localparam int LDH  = 4;
    localparam int CLRW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    logic clr_req = 1'b0;
    logic [DW-1:0] wr_code = '0;
    logic busy, done, dac_sclk, dac_sdo, dac_ld_n, dac_clr_n;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_wr_ctrl #(
        .DATA_W(DW), .SCK_HI_CYC(HI), .SCK_LO_CYC(LO), .LD_SU_CYC(LDSU),
        .LD_W_CYC(LDW), .LD_HOLD_CYC(LDH), .CLR_CYC(CLRW)
    ) u_sdac_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_code(wr_code),
        .clr_req(clr_req), .busy(busy), .done(done), .dac_sclk(dac_sclk),
        .dac_sdo(dac_sdo), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n)
    );

    // pin monitor
    int cyc = 0, rises = 0, hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0, bad_sdo = 0;
    int last_fall = 0, ld_fall = 0, ld_rise = 0, ld_len = 0, ld_pulses = 0;
    int clr_fall = 0, clr_len = 0, clr_pulses = 0, overlap = 0, ld_in_sclk = 0;
    int busy_fall = 0, dones = 0, done_cyc = 0;
    logic [DW-1:0] word = '0;
    logic p_sclk = 1'b0, p_sdo = 1'b0, p_ld = 1'b1, p_clr = 1'b1, p_busy = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (dac_sclk) begin
                if (!p_sclk) begin
                    if (rises > 0 && lo_run != LO) bad_lo++;
                    rises++;
                    word = {word[DW-2:0], dac_sdo};
                    hi_run = 1;
                end else begin
                    hi_run++;
                    if (dac_sdo != p_sdo) bad_sdo++;
                end
            end else begin
                if (p_sclk) begin
                    if (hi_run != HI) bad_hi++;
                    last_fall = cyc;
                    lo_run = 1;
                end else begin
                    lo_run++;
                end
            end
            if (!dac_ld_n && p_ld) begin ld_fall = cyc; ld_pulses++; end
            if (dac_ld_n && !p_ld) begin ld_rise = cyc; ld_len = cyc - ld_fall; end
            if (!dac_clr_n && p_clr) begin clr_fall = cyc; clr_pulses++; end
            if (dac_clr_n && !p_clr) clr_len = cyc - clr_fall;
            if (!dac_ld_n && !dac_clr_n) overlap++;
            if (!dac_ld_n && dac_sclk) ld_in_sclk++;
            if (!busy && p_busy) busy_fall = cyc;
            if (done) begin dones++; done_cyc = cyc; end
            p_sclk = dac_sclk; p_sdo = dac_sdo; p_ld = dac_ld_n;
            p_clr = dac_clr_n; p_busy = busy;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        rises = 0; bad_hi = 0; bad_lo = 0; bad_sdo = 0; ld_pulses = 0;
        clr_pulses = 0; overlap = 0; ld_in_sclk = 0; dones = 0; word = '0;
        ld_len = 0; clr_len = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input bit w, input bit c, input logic [DW-1:0] code);
        @(posedge clk); #1;
        wr_req = w; clr_req = c; wr_code = code;
        @(posedge clk); #1;
        wr_req = 1'b0; clr_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 sclk in reset", int'(dac_sclk), 0);
        chk("R1 ld_n in reset", int'(dac_ld_n), 1);
        chk("R1 clr_n in reset", int'(dac_clr_n), 1);
        chk("R1 busy in reset", int'(busy), 1);
        @(posedge clk); #1; rst_n = 1'b1;
        wait_idle();
        chk("R1 boot clear count", clr_pulses, 1);
        chk("R1 boot clear width", clr_len, CLRW);
        chk("R1 no clock at boot", rises, 0);
        chk("R1 no load at boot", ld_pulses, 0);
        chk("R1 idle after boot", int'(busy), 0);
    endtask

    task automatic t_write(input logic [DW-1:0] code);
        clear_stats();
        pulse(1'b1, 1'b0, code);
        @(negedge clk);
        chk("R6 busy after accept", int'(busy), 1);
        wait_idle();
        chk("R2 word", int'(word), int'(code));
        chk("R2 rising edges", rises, DW);
        chk("R3 high phase errors", bad_hi, 0);
        chk("R3 low phase errors", bad_lo, 0);
        chk("R3 sclk idles low", int'(dac_sclk), 0);
        chk("R4 sdo moved while high", bad_sdo, 0);
        chk("R5 load setup", ld_fall - last_fall, LDSU);
        chk("R5 load width", ld_len, LDW);
        chk("R5 load count", ld_pulses, 1);
        chk("R5 load during sclk high", ld_in_sclk, 0);
        chk("R6 load hold", busy_fall - ld_rise, LDH);
        chk("R6 done count", dones, 1);
        chk("R6 done with busy fall", done_cyc, busy_fall);
        chk("R9 overlap", overlap, 0);
    endtask

    task automatic t_ignored();
        clear_stats();
        pulse(1'b1, 1'b0, 12'h3C6);
        repeat (20) @(posedge clk);
        pulse(1'b1, 1'b1, 12'hC39);
        wait_idle();
        chk("R7 word kept", int'(word), 12'h3C6);
        chk("R7 edges", rises, DW);
        chk("R7 no clear", clr_pulses, 0);
        chk("R7 one load", ld_pulses, 1);
        chk("R7 one done", dones, 1);
    endtask

    task automatic t_clear(input bit with_write);
        clear_stats();
        pulse(with_write, 1'b1, 12'h5A5);
        @(negedge clk);
        chk("R8 busy in clear", int'(busy), 1);
        wait_idle();
        chk("R8 clear count", clr_pulses, 1);
        chk("R8 clear width", clr_len, CLRW);
        chk("R8 no clock", rises, 0);
        chk("R8 no load", ld_pulses, 0);
        chk("R8 no done", dones, 0);
        chk("R9 overlap", overlap, 0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write(12'hA5C);
        t_write(12'hFFF);
        t_write(12'h000);
        t_write(12'h001);
        t_write(12'h800);
        t_ignored();
        t_clear(1'b0);
        t_clear(1'b1);
        t_write(12'h6B2);
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule